// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synchronous single-port memory with 36-bit words split into four 9-bit byte lanes. It accepts a new read or write on every clock edge, and it never needs an idle cycle when the bus direction changes. Reads are pipelined: a read returns its word after the second active edge. Write data arrives late, two active edges after its address. Because of this, a read issued right after a write uses the same data-bus slots as a write issued right after a read. A bypass merges the write data that is still in flight into reads of the same address.

A command is loaded when the load/advance input is low. When that input is high, the block repeats the previous command type (read, write or deselect) at the next address of a four-word burst. An internal sequencer produces the burst addresses in linear or interleaved order, chosen by a parameter. An active-low clock enable freezes the whole pipeline. The output enable acts without waiting for the clock. A sleep request parks the block after two edges and releases it two edges after the request drops. The memory contents are kept through sleep.

Top module: `zbt_sram`

## Requirements
- R1: After a synchronous reset the block drives no data: `rvalid_o` is 0 and `rdata_o` is all zeros. The pipeline holds deselect.
- R2: On an edge where `cke_n_i` is high, every command input and `wdata_i` are ignored and all pipeline registers and the output hold their values.
- R3: With `cke_n_i` low and `adv_i` low on an edge, `sel_n_i` high loads a deselect. Otherwise `wr_n_i` high loads a read and `wr_n_i` low loads a write, both at `cmd_addr_i`.
- R4: A read loaded on edge k shows its word on `rdata_o` with `rvalid_o` high after edge k+1. It stays there until the next active edge.
- R5: The data for a write loaded on edge k is taken from `wdata_i` on the second active edge after k.
- R6: `be_n_i[i]`, sampled with each write command, enables lane i (bits 9i+8 down to 9i) when low. A write with all four high changes no word.
- R7: `adv_i` high repeats the previous command type at the next burst address. Address bits above bit 1 stay fixed. Bits [1:0] are start+n mod 4 in linear mode (`INTERLEAVE`=0), and start XOR n in interleaved mode, for the n-th address after the start.
- R8: A deselect, or a continued deselect after a deselect, leaves `rvalid_o` low and `rdata_o` zero after the following edge.
- R9: `oe_n_i` acts without a clock edge. While it is high, `rvalid_o` is 0 and `rdata_o` is zero, and a read completing in that state is consumed as a dummy read.
- R10: A high `sleep_i` sampled on edge s lets a command on edge s+1 through and ignores commands from edge s+2 on. While asleep, no data is driven and the contents are kept. After `sleep_i` is sampled low on edge w, commands are accepted again from edge w+2.
- R11: A read whose address matches a write still waiting for its data returns, lane by lane, the pending write data for enabled lanes and the stored word for the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_addr_i | input | AW | Word address for a loaded command |
| sel_n_i | input | 1 | Active-low select; high on a load gives a deselect |
| adv_i | input | 1 | Low loads a new command, high advances the burst |
| wr_n_i | input | 1 | High read, low write (on a load) |
| be_n_i | input | LANES | Active-low byte-lane write enables |
| cke_n_i | input | 1 | Active-low clock enable |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| sleep_i | input | 1 | Sleep request |
| wdata_i | input | DW | Late write data |
| rdata_o | output | DW | Read data, zero when not driven |
| rvalid_o | output | 1 | Read data is being driven |

## Verification
The main function is tested with several mixes. Back-to-back writes followed by reads show that the read latency and the late-write slot line up. A read placed two slots behind a write to the same address separates a working bypass from a stale array read. A partial-lane write and an all-high abort each face that bypass, which shows per-lane merging. Four-beat bursts that start at an offset of one are read by a linear and an interleaved instance together, so the wrap order of each is told apart. Clock-enable stalls, an output-enable toggle without a clock edge, and a sleep window with commands on its edges show which edges are honoured.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
  parameter int AW         = 10,
  parameter bit INTERLEAVE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nx;
  logic [1:0]    low_nx;

  assign cnt_nx = cnt_q + 2'd1;

  generate
    if (INTERLEAVE) begin : g_xor
      assign low_nx = base_q[1:0] ^ cnt_nx;
    end else begin : g_lin
      assign low_nx = base_q[1:0] + cnt_nx;
    end
  endgenerate

  assign addr_o = load_i ? addr_i : {base_q[AW-1:2], low_nx};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else if (step_i) begin
      if (load_i) begin
        base_q <= addr_i;
        cnt_q  <= 2'd0;
      end else begin
        cnt_q  <= cnt_nx;
      end
    end
  end

  // R7: consecutive burst beats never repeat the low address bits
  p_burst_moves_r7: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i && $past(step_i) && !$past(rst))
      |-> addr_o[1:0] != $past(addr_o[1:0]));
endmodule

// File: rtl/zbt_sleep_ctl.sv
module zbt_sleep_ctl (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  output logic asleep_o
);
  logic [1:0] sl_q;

  always_ff @(posedge clk) begin
    if (rst) sl_q <= 2'b00;
    else     sl_q <= {sl_q[0], sleep_i};
  end

  assign asleep_o = sl_q[1];

  // R10: a request held over two edges puts the block to sleep
  p_sleep_entry_r10: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && $past(sleep_i) && !$past(rst)) |=> asleep_o);
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [LANES-1:0] wr_be_n_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_word;
  logic [DW-1:0] merged;
  logic          hit;

  always_ff @(posedge clk) begin
    if (en_i && wr_en_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (!wr_be_n_i[l]) mem_q[wr_addr_i][l*LANE_W +: LANE_W] <= wr_data_i[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_word = mem_q[rd_addr_i];
  assign hit     = wr_en_i && (wr_addr_i == rd_addr_i);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*LANE_W +: LANE_W] = (hit && !wr_be_n_i[l])
        ? wr_data_i[l*LANE_W +: LANE_W] : rd_word[l*LANE_W +: LANE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                  rdata_o <= '0;
    else if (en_i && rd_en_i) rdata_o <= merged;
  end

  // R11: a full-word write landing on the read address is what the read returns
  p_bypass_full_r11: assert property (@(posedge clk) disable iff (rst)
    (en_i && rd_en_i && wr_en_i && rd_addr_i == wr_addr_i && wr_be_n_i == '0)
      |=> rdata_o == $past(wr_data_i));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int DEPTH      = 1024,
  parameter int LANES      = 4,
  parameter int LANE_W     = 9,
  parameter bit INTERLEAVE = 1'b0,
  localparam int AW        = $clog2(DEPTH),
  localparam int DW        = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic             sel_n_i,
  input  logic             adv_i,
  input  logic             wr_n_i,
  input  logic [LANES-1:0] be_n_i,
  input  logic             cke_n_i,
  input  logic             oe_n_i,
  input  logic             sleep_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o
);
  logic             go;
  logic             asleep;
  logic             accept;
  op_e              new_op, last_op;
  op_e              c1_op, c2_op;
  logic [AW-1:0]    seq_addr, c1_addr, c2_addr;
  logic [LANES-1:0] c1_be, c2_be;
  logic             rd_q;
  logic [DW-1:0]    arr_q;

  assign go     = !cke_n_i;
  assign accept = go && !asleep;

  zbt_sleep_ctl u_sleep (
    .clk      (clk),
    .rst      (rst),
    .sleep_i  (sleep_i),
    .asleep_o (asleep)
  );

  zbt_burst_seq #(.AW(AW), .INTERLEAVE(INTERLEAVE)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .step_i (accept),
    .load_i (!adv_i),
    .addr_i (cmd_addr_i),
    .addr_o (seq_addr)
  );

  always_comb begin
    if (asleep)      new_op = OP_IDLE;
    else if (!adv_i) new_op = sel_n_i ? OP_IDLE : (wr_n_i ? OP_RD : OP_WR);
    else             new_op = last_op;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c1_op   <= OP_IDLE;
      c2_op   <= OP_IDLE;
      last_op <= OP_IDLE;
      c1_addr <= '0;
      c2_addr <= '0;
      c1_be   <= '1;
      c2_be   <= '1;
      rd_q    <= 1'b0;
    end else if (go) begin
      c1_op   <= new_op;
      c1_addr <= seq_addr;
      c1_be   <= be_n_i;
      c2_op   <= c1_op;
      c2_addr <= c1_addr;
      c2_be   <= c1_be;
      last_op <= new_op;
      rd_q    <= (c1_op == OP_RD);
    end
  end

  zbt_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk       (clk),
    .rst       (rst),
    .en_i      (go),
    .rd_en_i   (c1_op == OP_RD),
    .rd_addr_i (c1_addr),
    .wr_en_i   (c2_op == OP_WR),
    .wr_addr_i (c2_addr),
    .wr_be_n_i (c2_be),
    .wr_data_i (wdata_i),
    .rdata_o   (arr_q)
  );

  assign rvalid_o = rd_q && !oe_n_i && !asleep;
  assign rdata_o  = rvalid_o ? arr_q : '0;

  // R2: a stalled edge moves nothing along the pipeline
  p_freeze_r2: assert property (@(posedge clk) disable iff (rst)
    cke_n_i |=> ($stable(c1_op) && $stable(c2_op) && $stable(rd_q)));

  // R8: a deselect reaching the read stage leaves the bus undriven
  p_desel_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (go && c1_op == OP_IDLE) |=> !rvalid_o);

  // R10: commands offered while asleep enter the pipeline as deselects
  p_sleep_block_r10: assert property (@(posedge clk) disable iff (rst)
    (go && asleep) |=> c1_op == OP_IDLE);
endmodule

// File: tb/zbt_sram_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  addr;
  logic        sel_n, adv, wr_n, cke_n, oe_n, slp;
  logic [3:0]  be_n;
  logic [35:0] wdata;
  logic [35:0] rd_lin, rd_il;
  logic        rv_lin, rv_il;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  zbt_sram #(.INTERLEAVE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .cmd_addr_i(addr), .sel_n_i(sel_n), .adv_i(adv),
    .wr_n_i(wr_n), .be_n_i(be_n), .cke_n_i(cke_n), .oe_n_i(oe_n),
    .sleep_i(slp), .wdata_i(wdata), .rdata_o(rd_lin), .rvalid_o(rv_lin));

  zbt_sram #(.INTERLEAVE(1'b1)) dut_il (
    .clk(clk), .rst(rst), .cmd_addr_i(addr), .sel_n_i(sel_n), .adv_i(adv),
    .wr_n_i(wr_n), .be_n_i(be_n), .cke_n_i(cke_n), .oe_n_i(oe_n),
    .sleep_i(slp), .wdata_i(wdata), .rdata_o(rd_il), .rvalid_o(rv_il));

  localparam logic [35:0] Z  = 36'h0;
  localparam logic [35:0] D0 = 36'h123456789;
  localparam logic [35:0] D1 = 36'hABCDEF012;
  localparam logic [35:0] D2 = 36'h13579BDF2;
  localparam logic [35:0] D3 = 36'hFFFFFFEA5;
  localparam logic [35:0] D4 = 36'h0F0F0F0F0;
  localparam logic [35:0] M8 = {D0[35:9], D3[8:0]};
  localparam logic [35:0] E0 = 36'h111111111;
  localparam logic [35:0] E1 = 36'h222222222;
  localparam logic [35:0] E2 = 36'h333333333;
  localparam logic [35:0] E3 = 36'h444444444;
  localparam logic [35:0] F0 = 36'h5A5A5A5A5;
  localparam logic [35:0] F1 = 36'h987654321;
  localparam logic [35:0] DX = 36'hEEEEEEEEE;
  localparam logic [35:0] MX = {DX[35:27], D2[26:18], DX[17:9], D2[8:0]};

  typedef struct packed {
    logic        sel_n;
    logic        adv;
    logic        wr_n;
    logic [3:0]  be_n;
    logic [9:0]  addr;
    logic [35:0] wd;
    logic        ev;
    logic [35:0] ed;
    logic [35:0] ed_il;
  } vec_t;

  // one row per active edge; expected value is observed just after that edge
  localparam vec_t VEC [24] = '{
    '{1'b0,1'b0,1'b0,4'b0000,10'h010,Z ,1'b0,Z ,Z },  // 0 write 010 (R3)
    '{1'b0,1'b0,1'b0,4'b0000,10'h011,Z ,1'b0,Z ,Z },  // 1 write 011
    '{1'b0,1'b0,1'b1,4'b0000,10'h010,D0,1'b0,Z ,Z },  // 2 read 010, data for 010 (R5)
    '{1'b0,1'b0,1'b0,4'b0000,10'h012,D1,1'b1,D0,D0},  // 3 write 012, read out (R4)
    '{1'b0,1'b0,1'b1,4'b0000,10'h012,Z ,1'b0,Z ,Z },  // 4 read 012 behind its write
    '{1'b0,1'b0,1'b1,4'b0000,10'h011,D2,1'b1,D2,D2},  // 5 bypass full word (R11)
    '{1'b0,1'b0,1'b0,4'b1110,10'h010,Z ,1'b1,D1,D1},  // 6 lane-0 write 010 (R6)
    '{1'b0,1'b0,1'b1,4'b0000,10'h010,Z ,1'b0,Z ,Z },  // 7 read 010
    '{1'b1,1'b0,1'b1,4'b1111,10'h000,D3,1'b1,M8,M8},  // 8 deselect, lane merge bypass (R11)
    '{1'b1,1'b1,1'b1,4'b1111,10'h000,Z ,1'b0,Z ,Z },  // 9 continue deselect (R8)
    '{1'b0,1'b0,1'b0,4'b1111,10'h011,Z ,1'b0,Z ,Z },  // 10 aborted write (R6)
    '{1'b0,1'b0,1'b1,4'b0000,10'h011,Z ,1'b0,Z ,Z },  // 11 read 011
    '{1'b1,1'b0,1'b1,4'b1111,10'h000,D4,1'b1,D1,D1},  // 12 abort changes nothing
    '{1'b1,1'b0,1'b1,4'b1111,10'h000,Z ,1'b0,Z ,Z },  // 13 deselect (R8)
    '{1'b0,1'b0,1'b0,4'b0000,10'h020,Z ,1'b0,Z ,Z },  // 14 burst write start (R7)
    '{1'b0,1'b1,1'b0,4'b0000,10'h000,Z ,1'b0,Z ,Z },  // 15
    '{1'b0,1'b1,1'b0,4'b0000,10'h000,E0,1'b0,Z ,Z },  // 16
    '{1'b0,1'b1,1'b0,4'b0000,10'h000,E1,1'b0,Z ,Z },  // 17
    '{1'b0,1'b0,1'b1,4'b0000,10'h021,E2,1'b0,Z ,Z },  // 18 burst read from offset 1
    '{1'b0,1'b1,1'b1,4'b0000,10'h000,E3,1'b1,E1,E1},  // 19
    '{1'b0,1'b1,1'b1,4'b0000,10'h000,Z ,1'b1,E2,E0},  // 20 linear vs interleaved (R7)
    '{1'b0,1'b1,1'b1,4'b0000,10'h000,Z ,1'b1,E3,E3},  // 21
    '{1'b1,1'b0,1'b1,4'b1111,10'h000,Z ,1'b1,E0,E2},  // 22 wrap (R7)
    '{1'b1,1'b0,1'b1,4'b1111,10'h000,Z ,1'b0,Z ,Z }   // 23 (R8)
  };

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic v, input logic [35:0] d,
                     input logic ev, input logic [35:0] ed);
    checks++;
    if (v !== ev || d !== ed) begin
      failures++;
      $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h", tag, v, d, ev, ed);
    end
  endtask

  task automatic cmd(input logic s, input logic a, input logic w,
                     input logic [3:0] b, input logic [9:0] ad, input logic [35:0] wd);
    sel_n = s; adv = a; wr_n = w; be_n = b; addr = ad; wdata = wd;
  endtask

  task automatic idle(input logic [35:0] wd);
    cmd(1'b1, 1'b0, 1'b1, 4'b1111, 10'h000, wd);
  endtask

  initial begin
    rst = 1'b1; cke_n = 1'b0; oe_n = 1'b0; slp = 1'b0;
    idle(Z);
    repeat (3) step();
    rst = 1'b0;
    // R1: reset state
    chk("R1 reset linear", rv_lin, rd_lin, 1'b0, Z);
    chk("R1 reset interleaved", rv_il, rd_il, 1'b0, Z);
    step();
    chk("R1 idle after reset", rv_lin, rd_lin, 1'b0, Z);

    for (int i = 0; i < 24; i++) begin
      cmd(VEC[i].sel_n, VEC[i].adv, VEC[i].wr_n, VEC[i].be_n, VEC[i].addr, VEC[i].wd);
      step();
      chk($sformatf("vector %0d linear R3 R4 R5 R6 R7 R8 R11", i), rv_lin, rd_lin, VEC[i].ev, VEC[i].ed);
      chk($sformatf("vector %0d interleaved R7", i), rv_il, rd_il, VEC[i].ev, VEC[i].ed_il);
    end

    // R9: output enable high hides a completed read; it acts without an edge
    oe_n = 1'b1;
    cmd(1'b0, 1'b0, 1'b1, 4'b0000, 10'h011, Z);
    step();
    idle(Z);
    step();
    chk("R9 dummy read undriven", rv_lin, rd_lin, 1'b0, Z);
    oe_n = 1'b0;
    #1;
    chk("R9 async enable", rv_lin, rd_lin, 1'b1, D1);
    step();
    chk("R9 R8 after deselect", rv_lin, rd_lin, 1'b0, Z);

    // R2: stalls freeze the pipeline and drop inputs
    cmd(1'b0, 1'b0, 1'b1, 4'b0000, 10'h012, Z);
    step();
    cke_n = 1'b1;
    cmd(1'b0, 1'b0, 1'b0, 4'b0000, 10'h011, D4);
    step();
    chk("R2 stalled before data", rv_lin, rd_lin, 1'b0, Z);
    step();
    chk("R2 still stalled", rv_lin, rd_lin, 1'b0, Z);
    cke_n = 1'b0;
    idle(D4);
    step();
    chk("R2 resumes read", rv_lin, rd_lin, 1'b1, D2);
    cke_n = 1'b1;
    step();
    chk("R2 output held", rv_lin, rd_lin, 1'b1, D2);
    cke_n = 1'b0;
    idle(D4);
    step();
    chk("R2 R8 released", rv_lin, rd_lin, 1'b0, Z);
    cmd(1'b0, 1'b0, 1'b1, 4'b0000, 10'h011, D4);
    step();
    idle(D4);
    step();
    chk("R2 stalled write ignored", rv_lin, rd_lin, 1'b1, D1);

    // R6: lanes 1 and 3 written, lanes 0 and 2 kept
    cmd(1'b0, 1'b0, 1'b0, 4'b0101, 10'h012, Z);
    step();
    idle(Z);
    step();
    idle(DX);
    step();
    cmd(1'b0, 1'b0, 1'b1, 4'b0000, 10'h012, Z);
    step();
    idle(Z);
    step();
    chk("R6 partial lanes", rv_lin, rd_lin, 1'b1, MX);

    // R10: sleep entry, blocking, retention and wake timing
    slp = 1'b1;
    idle(Z);
    step();                                            // s0
    cmd(1'b0, 1'b0, 1'b0, 4'b0000, 10'h013, Z);        // accepted on s1
    step();
    cmd(1'b0, 1'b0, 1'b0, 4'b0000, 10'h011, Z);        // ignored on s2
    step();
    chk("R10 asleep undriven", rv_lin, rd_lin, 1'b0, Z);
    idle(F0);
    step();
    idle(F1);
    step();
    chk("R10 asleep still undriven", rv_lin, rd_lin, 1'b0, Z);
    cmd(1'b0, 1'b0, 1'b1, 4'b0000, 10'h013, Z);
    step();
    chk("R10 read while asleep", rv_lin, rd_lin, 1'b0, Z);
    slp = 1'b0;
    idle(Z);
    step();                                            // w
    cmd(1'b0, 1'b0, 1'b1, 4'b0000, 10'h012, Z);        // w+1 ignored
    step();
    cmd(1'b0, 1'b0, 1'b1, 4'b0000, 10'h011, Z);        // w+2 accepted
    step();
    chk("R10 no early wake", rv_lin, rd_lin, 1'b0, Z);
    cmd(1'b0, 1'b0, 1'b1, 4'b0000, 10'h013, Z);
    step();
    chk("R10 contents kept", rv_lin, rd_lin, 1'b1, D1);
    idle(Z);
    step();
    chk("R10 write before sleep done", rv_lin, rd_lin, 1'b1, F0);
    step();
    chk("R10 R8 idle", rv_lin, rd_lin, 1'b0, Z);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule